// File: doc/BRIEF.md
# Sub-Pixel Edge Timing Generator

This block produces the fast clocks of an image-sensor readout path: a reset-gate clock, four horizontal clocks and two sample strobes. It runs on a fast clock at 48 times the pixel rate. A phase counter splits each pixel period into 48 positions, numbered 0 to 47. A pixel-start input realigns the counter. Each clock channel has a programmed rising position and a programmed falling position, plus an inversion bit. Each strobe has one programmed position.

Positions are held as 6-bit quadrant codes. The upper two bits pick a group of twelve positions and the lower four bits give an offset inside that group. The codes therefore have gaps, and each one is decoded before it is compared with the counter. Software writes the codes through a parallel write port into a shadow set. The shadow set is copied to the working set only when the counter enters position 0, so a pulse never changes shape partway through a period.

Top module: `subpix_edge_gen`

## Requirements
- R1: The phase counter starts at 0 after reset, advances by one each fast clock, and wraps from 47 to 0, so every undisturbed period is 48 fast clocks long.
- R2: When `pix_start` is high in a cycle, the counter is 0 in the next cycle, whatever its value was.
- R3: A code c decodes to position 12*c[5:4] + c[3:0]. A code with c[3:0] in 12..15 is invalid.
- R4: Each clock channel holds an internal level. The level is set at the rising position and cleared at the falling position. An output shows the level one cycle late, so for rise r < fall f the channel is high in the cycles whose phase is r+1 through f.
- R5: When f < r, the pulse wraps across the period boundary: it is high from phase r+1 through 47 and from 0 through f.
- R6: Register 6 holds the inversion bits: bit 0 inverts `rg` and bit 1 inverts the horizontal clocks. A value of 1 inverts the output.
- R7: `h1` and `h3` carry the horizontal channel, and `h2` and `h4` are always their logical inverse.
- R8: If the rising and falling codes are valid and decode to the same position, the channel's internal level stays low for the whole period.
- R9: An invalid rising or falling code produces no edge, so the level holds its previous value.
- R10: A strobe is high for exactly one fast clock per period, in the cycle whose phase is its position + 1 (mod 48). A strobe with an invalid code never fires.
- R11: Write selects: 0 `rg` rise, 1 `rg` fall, 2 horizontal rise, 3 horizontal fall, 4 `shp` position, 5 `shd` position, 6 inversion bits. Select 7 changes nothing. A write goes to the shadow set. It takes effect from the next period start and leaves the rest of the current period unchanged.
- R12: After reset, every code and inversion bit is 0. `rg`, `h1`, `h3`, `shp` and `shd` are low, and `h2` and `h4` are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, 48 times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| pix_start | input | 1 | Realigns the phase counter to 0 in the next cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (see R11) |
| wr_data | input | 6 | Quadrant code, or inversion bits for select 6 |
| rg | output | 1 | Reset-gate clock |
| h1 | output | 1 | Horizontal clock, true phase |
| h2 | output | 1 | Horizontal clock, inverse of h1 |
| h3 | output | 1 | Horizontal clock, true phase |
| h4 | output | 1 | Horizontal clock, inverse of h3 |
| shp | output | 1 | Reset-level sample strobe |
| shd | output | 1 | Data-level sample strobe |

## Verification
The bench builds the block with its default package values: four quadrants of twelve positions, two clock channels and two strobes. These values make a full 48-position period cheap to sweep cycle by cycle. Every quadrant, the gap codes, positions 0 and 47 and the wrap are all reachable. Mid-period writes and a mid-period realignment check the deferred load and the counter restart against a phase model that the bench keeps for itself.

// File: rtl/subpix_pkg.sv
package subpix_pkg;
  parameter int NUM_QUAD     = 4;
  parameter int POS_PER_QUAD = 12;
  parameter int OFF_W        = 4;
  parameter int NUM_EDGE     = 2;
  parameter int NUM_STRB     = 2;

  localparam int NUM_POS = NUM_QUAD * POS_PER_QUAD;
  localparam int QSEL_W  = $clog2(NUM_QUAD);
  localparam int CODE_W  = QSEL_W + OFF_W;
  localparam int PH_W    = $clog2(NUM_POS);
  localparam int NUM_SEL = 2 * NUM_EDGE + NUM_STRB + 1;
  localparam int SEL_W   = $clog2(NUM_SEL + 1);

  typedef logic [PH_W-1:0]   phase_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEL_W-1:0]  sel_t;

  localparam phase_t PH_LAST = phase_t'(NUM_POS - 1);

  typedef struct packed {
    logic   ok;
    phase_t pos;
  } edge_pos_t;

  typedef struct packed {
    code_t [NUM_EDGE-1:0] rise;
    code_t [NUM_EDGE-1:0] fall;
    code_t [NUM_STRB-1:0] spos;
    logic  [NUM_EDGE-1:0] pol;
  } cfg_t;

  // quadrant code -> linear position; offsets past the group size are gaps
  function automatic edge_pos_t decode_code(input code_t c);
    edge_pos_t d;
    logic [QSEL_W-1:0] q;
    logic [OFF_W-1:0]  o;
    q     = c[CODE_W-1:OFF_W];
    o     = c[OFF_W-1:0];
    d.ok  = (int'(o) < POS_PER_QUAD);
    d.pos = phase_t'(int'(q) * POS_PER_QUAD + int'(o));
    return d;
  endfunction
endpackage

// File: rtl/subpix_phase_ctr.sv
module subpix_phase_ctr
  import subpix_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   pix_start,
  output phase_t ph,
  output logic   wrap_nxt
);
  phase_t ph_nxt;

  always_comb begin
    if (pix_start || ph == PH_LAST) ph_nxt = '0;
    else                            ph_nxt = ph + 1'b1;
  end

  assign wrap_nxt = (ph_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) ph <= '0;
    else     ph <= ph_nxt;
  end

  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    ph <= PH_LAST);
  // R1
  phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!pix_start && ph == PH_LAST) |=> (ph == '0));
  // R2
  resync_chk: assert property (@(posedge clk) disable iff (rst)
    pix_start |=> (ph == '0));
endmodule

// File: rtl/subpix_cfg_regs.sv
module subpix_cfg_regs
  import subpix_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   wr_en,
  input  sel_t   wr_sel,
  input  code_t  wr_data,
  input  logic   load,
  input  phase_t ph,
  output cfg_t   act
);
  cfg_t shd_q, shd_nxt, act_q;

  always_comb begin
    shd_nxt = shd_q;
    if (wr_en) begin
      for (int i = 0; i < NUM_EDGE; i++) begin
        if (int'(wr_sel) == 2 * i)     shd_nxt.rise[i] = wr_data;
        if (int'(wr_sel) == 2 * i + 1) shd_nxt.fall[i] = wr_data;
      end
      for (int j = 0; j < NUM_STRB; j++) begin
        if (int'(wr_sel) == 2 * NUM_EDGE + j) shd_nxt.spos[j] = wr_data;
      end
      if (int'(wr_sel) == 2 * NUM_EDGE + NUM_STRB)
        shd_nxt.pol = wr_data[NUM_EDGE-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      shd_q <= shd_nxt;
      if (load) act_q <= shd_nxt;
    end
  end

  assign act = act_q;

  // R11
  cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> (ph == '0));
endmodule

// File: rtl/subpix_edge_unit.sv
module subpix_edge_unit
  import subpix_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t ph,
  input  code_t  rise_c,
  input  code_t  fall_c,
  input  logic   pol,
  output logic   o,
  output logic   o_n
);
  edge_pos_t rd, fd;
  logic      lvl_q, lvl_nxt, same_pos;

  assign rd       = decode_code(rise_c);
  assign fd       = decode_code(fall_c);
  assign same_pos = rd.ok && fd.ok && (rd.pos == fd.pos);

  always_comb begin
    if (same_pos)                    lvl_nxt = 1'b0;
    else if (rd.ok && ph == rd.pos)  lvl_nxt = 1'b1;
    else if (fd.ok && ph == fd.pos)  lvl_nxt = 1'b0;
    else                             lvl_nxt = lvl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      o     <= 1'b0;
      o_n   <= 1'b1;
    end else begin
      lvl_q <= lvl_nxt;
      o     <= lvl_nxt ^ pol;
      o_n   <= ~(lvl_nxt ^ pol);
    end
  end

  // R8
  equal_low_chk: assert property (@(posedge clk) disable iff (rst)
    same_pos |=> (o == $past(pol)));
endmodule

// File: rtl/subpix_strobe_unit.sv
module subpix_strobe_unit
  import subpix_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t ph,
  input  code_t  pos_c,
  output logic   stb
);
  edge_pos_t sd;

  assign sd = decode_code(pos_c);

  always_ff @(posedge clk) begin
    if (rst) stb <= 1'b0;
    else     stb <= sd.ok && (ph == sd.pos);
  end

  // R10
  strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
    stb |-> $past(sd.ok));
endmodule

// File: rtl/subpix_edge_gen.sv
module subpix_edge_gen
  import subpix_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_start,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [CODE_W-1:0] wr_data,
  output logic              rg,
  output logic              h1,
  output logic              h2,
  output logic              h3,
  output logic              h4,
  output logic              shp,
  output logic              shd
);
  phase_t ph;
  logic   wrap_nxt;
  cfg_t   act;
  logic [NUM_EDGE-1:0] edge_o, edge_on;
  logic [NUM_STRB-1:0] strb;

  subpix_phase_ctr u_ctr (
    .clk(clk), .rst(rst), .pix_start(pix_start), .ph(ph), .wrap_nxt(wrap_nxt)
  );

  subpix_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .load(wrap_nxt), .ph(ph), .act(act)
  );

  for (genvar i = 0; i < NUM_EDGE; i++) begin : g_edge
    subpix_edge_unit u_edge (
      .clk(clk), .rst(rst), .ph(ph),
      .rise_c(act.rise[i]), .fall_c(act.fall[i]), .pol(act.pol[i]),
      .o(edge_o[i]), .o_n(edge_on[i])
    );
    // R7
    comp_pair_chk: assert property (@(posedge clk) disable iff (rst)
      edge_on[i] != edge_o[i]);
  end

  for (genvar j = 0; j < NUM_STRB; j++) begin : g_strb
    subpix_strobe_unit u_strb (
      .clk(clk), .rst(rst), .ph(ph), .pos_c(act.spos[j]), .stb(strb[j])
    );
  end

  assign rg  = edge_o[0];
  assign h1  = edge_o[1];
  assign h3  = edge_o[1];
  assign h2  = edge_on[1];
  assign h4  = edge_on[1];
  assign shp = strb[0];
  assign shd = strb[1];

  // R7
  h_comp_chk: assert property (@(posedge clk) disable iff (rst)
    (h2 == ~h1) && (h4 == ~h3));
endmodule

// File: tb/subpix_edge_gen_bench.sv
module subpix_edge_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, pix_start = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [5:0] wr_data = '0;
  logic rg, h1, h2, h3, h4, shp, shd;
  int bph = 0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subpix_edge_gen u_subpix_edge_gen (
    .clk(clk), .rst(rst), .pix_start(pix_start), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rg(rg), .h1(h1), .h2(h2),
    .h3(h3), .h4(h4), .shp(shp), .shd(shd)
  );

  // bench model of the phase, from R1/R2
  always @(posedge clk) begin
    if (rst || pix_start) bph <= 0;
    else                  bph <= (bph == 47) ? 0 : bph + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s phase=%0d actual=%0d expected=%0d", tag, bph, act, exp);
    end
  endtask

  function automatic bit pulse_hi(input int r, input int f, input int p);
    int q = (p + 47) % 48;
    if (r == f) return 1'b0;
    if (r < f)  return (q >= r) && (q < f);
    return (q >= r) || (q < f);
  endfunction

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 6'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      while (bph != 0) @(negedge clk);
    end
  endtask

  task automatic chk_chan(input int ch, input int r, input int f, input bit pol, input string tag);
    bit e = pulse_hi(r, f, bph) ^ pol;
    if (ch == 0) chk(rg == e, tag, rg, e);
    else begin
      chk(h1 == e && h3 == e, tag, h1, e);
      chk(h2 == !e && h4 == !e, {tag, " R7"}, h2, !e);
    end
  endtask

  task automatic chk_period(input int ch, input int r, input int f, input bit pol, input string tag);
    for (int k = 0; k < 48; k++) begin
      chk_chan(ch, r, f, pol, tag);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(rg == 0 && h1 == 0 && h3 == 0, "R12 clocks low", rg, 0);
    chk(h2 == 1 && h4 == 1, "R12 inverse high", h2, 1);
    chk(shp == 0 && shd == 0, "R12 strobes low", shp, 0);
    rst = 1'b0;
    // reset codes are 0: strobes at phase 1, clocks stay low
    for (int k = 0; k < 96; k++) begin
      @(negedge clk);
      chk(shp == (bph == 1) && shd == (bph == 1), "R12 R1 default strobe", shp, bph == 1);
      chk(rg == 0 && h1 == 0, "R12 R8 default low", rg, 0);
    end
  endtask

  task automatic t_basic();
    wr(0, 'h05); wr(1, 'h18); wr(6, 0);
    settle();
    chk_period(0, 5, 20, 0, "R4 basic rg");
  endtask

  task automatic t_quadrant();
    wr(2, 'h26); wr(3, 'h39);
    settle();
    chk_period(1, 30, 45, 0, "R3 R4 quadrant h");
  endtask

  task automatic t_wrap();
    wr(2, 'h34); wr(3, 'h07);
    settle();
    chk_period(1, 40, 7, 0, "R5 wrap h");
  endtask

  task automatic t_polarity();
    wr(0, 'h05); wr(1, 'h18); wr(6, 1);
    settle();
    chk_period(0, 5, 20, 1, "R6 rg inverted");
    chk_period(1, 40, 7, 0, "R6 h not inverted");
    wr(6, 2);
    settle();
    chk_period(1, 40, 7, 1, "R6 h inverted");
    chk_period(0, 5, 20, 0, "R6 rg plain");
    wr(6, 0);
  endtask

  task automatic t_equal();
    wr(0, 'h12); wr(1, 'h12);
    settle();
    chk_period(0, 14, 14, 0, "R8 equal positions");
  endtask

  task automatic t_invalid();
    wr(2, 'h03); wr(3, 'h0D);
    settle();
    for (int k = 0; k < 48; k++) begin
      chk(h1 == 1 && h2 == 0, "R9 R3 invalid fall holds high", h1, 1);
      @(negedge clk);
    end
    wr(2, 'h1E); wr(3, 'h0A);
    settle();
    for (int k = 0; k < 48; k++) begin
      chk(h1 == 0 && h4 == 1, "R9 invalid rise holds low", h1, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_strobe();
    wr(4, 'h2B); wr(5, 'h3B);
    settle();
    for (int k = 0; k < 48; k++) begin
      chk(shp == (bph == 36), "R10 shp at 35", shp, bph == 36);
      chk(shd == (bph == 0), "R10 shd at 47 wraps", shd, bph == 0);
      @(negedge clk);
    end
    wr(4, 'h1F); wr(7, 'h00);
    settle();
    for (int k = 0; k < 48; k++) begin
      chk(shp == 0, "R10 invalid strobe silent", shp, 0);
      chk(shd == (bph == 0), "R11 select 7 ignored", shd, bph == 0);
      @(negedge clk);
    end
  endtask

  task automatic t_deferred();
    wr(0, 'h05); wr(1, 'h18); wr(6, 0);
    settle();
    while (bph != 10) @(negedge clk);
    wr(0, 'h26); wr(1, 'h34);
    while (bph != 0) begin
      chk_chan(0, 5, 20, 0, "R11 old config kept");
      @(negedge clk);
    end
    chk_period(0, 30, 40, 0, "R11 new config at start");
  endtask

  task automatic t_resync();
    wr(4, 'h02);
    settle();
    while (bph != 20) @(negedge clk);
    pix_start = 1'b1;
    @(negedge clk);
    pix_start = 1'b0;
    chk(bph == 0, "R2 bench phase", bph, 0);
    for (int k = 0; k < 60; k++) begin
      chk(shp == (bph == 3), "R2 strobe realigned", shp, bph == 3);
      chk_chan(0, 30, 40, 0, "R2 rg realigned");
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_quadrant();
    t_wrap();
    t_polarity();
    t_equal();
    t_invalid();
    t_strobe();
    t_deferred();
    t_resync();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule